// File: doc/BRIEF.md
# Burst Address Sequence Generator

This block supplies the two lowest address bits used by a memory array during a four-beat burst. When a burst begins, it captures a start value from the external address bus. On every following clock it either moves to the next beat of the burst or stays where it is, depending on an active-low advance strobe. A static order select picks one of two beat orderings. In interleaved order each beat is the start value XORed with the beat count. In linear order each beat is the start value plus the beat count, modulo four.

The upper address bits, chip-select qualification and the storage array sit outside this block. The effective low bits come straight from registered state, so they are valid in the cycle after the edge that loaded or stepped them. A one-bit indication tells the array whether the current beat is the freshly loaded start of a burst or a continuation of one.

Top module: `burst_seq_gen`

## Requirements
- R1: While `rst_n` is low at a rising edge, the start bits and the beat count clear to zero. After that edge `eff_lo` reads 00 and `first_beat` reads 0.
- R2: When `ld_burst` is high at a rising edge, `eff_lo` equals the sampled `ext_lo` after that edge and `first_beat` is 1, whatever the value of `adv_n`.
- R3: With `order_sel` high (interleaved), `eff_lo` is the loaded start XOR the beat count. For example, start 01 gives 01,00,11,10 and start 10 gives 10,11,00,01.
- R4: With `order_sel` low (linear), `eff_lo` is the loaded start plus the beat count, modulo 4. For example, start 01 gives 01,10,11,00.
- R5: When `ld_burst` is low and `adv_n` is low at a rising edge, the beat count increases by one modulo 4 and `first_beat` goes to 0.
- R6: When `ld_burst` is low and `adv_n` is high at a rising edge, `eff_lo` and `first_beat` keep their values. This inserts a wait state.
- R7: Four advances after a load bring `eff_lo` back to the start value in both orders, and `first_beat` stays 0.
- R8: `ext_lo` has no effect at an edge where `ld_burst` is low. `eff_lo` follows only the stored start and the beat count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous reset, active low |
| ld_burst | input | 1 | Begin a new burst from `ext_lo` (active high, overrides advance) |
| adv_n | input | 1 | Step to the next beat when low; hold the current beat when high |
| ext_lo | input | 2 | Low address bits from the external bus |
| order_sel | input | 1 | 1 = interleaved order, 0 = linear order; static during operation |
| eff_lo | output | 2 | Effective low address bits for the current beat |
| first_beat | output | 1 | 1 while the current beat is a freshly loaded start, 0 on continued beats |

## Verification
Directed bursts from each of the four start values, run in both orders, separate XOR sequencing from additive sequencing. Start values 01 and 11 are where the two orders first differ. Bursts with wait states inserted at random beats show that a suspend freezes the beat without losing its place. Loads issued together with an active advance show that a new burst overrides stepping. Random toggling of `ext_lo` while no load is pending shows that the stored start cannot be disturbed between loads.

// File: rtl/burst_pkg.sv
// Package: shared types and sequencing functions for the burst address generator.
// Assumes the beat count and start value have the same width.
package burst_pkg;

    // Beat ordering selected by the static order input
    typedef enum logic {
        ORD_LINEAR     = 1'b0,
        ORD_INTERLEAVE = 1'b1
    } order_e;

    // Interleaved beat: start XOR beat count
    function automatic logic [1:0] seq_interleave(input logic [1:0] start, input logic [1:0] cnt);
        return start ^ cnt;
    endfunction

    // Linear beat: start plus beat count, wrapping at four
    function automatic logic [1:0] seq_linear(input logic [1:0] start, input logic [1:0] cnt);
        return start + cnt;
    endfunction

endpackage

// File: rtl/burst_start_reg.sv
// Module: holds the start value of the current burst.
// Captures the external bits only on a load strobe; clears on synchronous
// active-low reset. Assumes the load strobe is already qualified upstream.
module burst_start_reg #(
    parameter int BEAT_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [BEAT_W-1:0] ext_in,
    output logic [BEAT_W-1:0] start_q
);

    // Capture the start value at a load, otherwise keep it
    always_ff @(posedge clk) begin
        if (!rst_n)
            start_q <= '0;
        else if (load)
            start_q <= ext_in;
    end

    // R8: without a load the stored start cannot move
    a_r8_start_held: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(start_q));

    // R2: a load stores exactly the sampled external bits
    a_r2_start_loaded: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (start_q == $past(ext_in)));

endmodule

// File: rtl/burst_beat_ctr.sv
// Module: beat counter and first-beat flag for a burst.
// A load clears the count and sets the flag. An active-low advance increments
// the count (wrapping at 2**BEAT_W) and clears the flag. Otherwise both hold.
module burst_beat_ctr #(
    parameter int BEAT_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              adv_n,
    output logic [BEAT_W-1:0] cnt_q,
    output logic              fresh_q
);

    localparam logic [BEAT_W-1:0] ONE = BEAT_W'(1);

    // Count beats: clear on load, step on advance, hold on suspend
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            fresh_q <= 1'b0;
        end else if (load) begin
            cnt_q   <= '0;
            fresh_q <= 1'b1;
        end else if (!adv_n) begin
            cnt_q   <= cnt_q + ONE;
            fresh_q <= 1'b0;
        end
    end

    // R1: reset clears the count and the flag
    a_r1_reset_clear: assert property (@(posedge clk)
        !rst_n |=> (cnt_q == '0 && !fresh_q));

    // R5: an advance steps the count by one and ends the first beat
    a_r5_step: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !adv_n) |=> (cnt_q == $past(cnt_q) + ONE && !fresh_q));

    // R6: a suspend keeps both count and flag
    a_r6_suspend: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && adv_n) |=> ($stable(cnt_q) && $stable(fresh_q)));

endmodule

// File: rtl/burst_order_map.sv
// Module: combinational map from start value and beat count to the effective
// low address bits. Assumes the order select is static while a burst runs.
module burst_order_map
    import burst_pkg::*;
(
    input  logic [1:0] start,
    input  logic [1:0] cnt,
    input  order_e     order,
    output logic [1:0] eff
);

    // Pick interleaved or linear sequencing
    always_comb begin
        if (order == ORD_INTERLEAVE)
            eff = seq_interleave(start, cnt);
        else
            eff = seq_linear(start, cnt);
    end

endmodule

// File: rtl/burst_seq_gen.sv
// Module: top of the burst address sequence generator.
// Loads a start value, then steps or holds through a four-beat burst in
// interleaved or linear order. Assumes order_sel is static and that the
// strobes are already qualified by the chip-select logic outside this block.
module burst_seq_gen
    import burst_pkg::*;
#(
    parameter int BEAT_W = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ld_burst,
    input  logic       adv_n,
    input  logic [1:0] ext_lo,
    input  logic       order_sel,
    output logic [1:0] eff_lo,
    output logic       first_beat
);

    logic [BEAT_W-1:0] start_q;
    logic [BEAT_W-1:0] cnt_q;
    logic              fresh_q;
    order_e            order;

    assign order = order_e'(order_sel);

    burst_start_reg #(.BEAT_W(BEAT_W)) u_start (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (ld_burst),
        .ext_in  (ext_lo),
        .start_q (start_q)
    );

    burst_beat_ctr #(.BEAT_W(BEAT_W)) u_ctr (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (ld_burst),
        .adv_n   (adv_n),
        .cnt_q   (cnt_q),
        .fresh_q (fresh_q)
    );

    burst_order_map u_map (
        .start (start_q),
        .cnt   (cnt_q),
        .order (order),
        .eff   (eff_lo)
    );

    assign first_beat = fresh_q;

    // R2: a load, with or without advance, presents the external bits next cycle
    a_r2_load_out: assert property (@(posedge clk) disable iff (!rst_n)
        ld_burst |=> (eff_lo == $past(ext_lo) && first_beat));

    // R6: a suspend freezes the visible beat
    a_r6_out_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!ld_burst && adv_n) |=> ($stable(eff_lo) && $stable(first_beat)));

endmodule

// File: tb/test_burst_seq_gen.sv
// Bench: directed corner bursts plus seeded random stimulus, checked against
// a bench-side model of the requirements.
module test_burst_seq_gen;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ld_burst = 1'b0;
    logic       adv_n = 1'b1;
    logic [1:0] ext_lo = 2'b00;
    logic       order_sel = 1'b1;
    logic [1:0] eff_lo;
    logic       first_beat;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    // Model state
    logic [1:0] m_start = 2'b00;
    logic [1:0] m_cnt   = 2'b00;
    logic       m_fresh = 1'b0;

    always #10 clk = ~clk;

    burst_seq_gen i_burst_seq_gen (
        .clk        (clk),
        .rst_n      (rst_n),
        .ld_burst   (ld_burst),
        .adv_n      (adv_n),
        .ext_lo     (ext_lo),
        .order_sel  (order_sel),
        .eff_lo     (eff_lo),
        .first_beat (first_beat)
    );

    // Expected beat from the ordering requirements (R3 XOR, R4 add mod 4)
    function automatic logic [1:0] exp_beat(input logic [1:0] s, input logic [1:0] c, input logic ord);
        logic [2:0] sum;
        sum = {1'b0, s} + {1'b0, c};
        if (ord) return s ^ c;
        return sum[1:0];
    endfunction

    task automatic check(input string tag, input logic [1:0] exp_e, input logic exp_f);
        checks++;
        if (eff_lo !== exp_e || first_beat !== exp_f) begin
            fails++;
            $display("FAIL %s: eff_lo=%b first_beat=%b expected eff_lo=%b first_beat=%b",
                     tag, eff_lo, first_beat, exp_e, exp_f);
        end
    endtask

    // Drive one cycle at the falling edge, update the model at the rising edge, then check
    task automatic cyc(input logic ld, input logic adv, input logic [1:0] ext, input string tag);
        @(negedge clk);
        ld_burst = ld;
        adv_n    = adv;
        ext_lo   = ext;
        @(posedge clk);
        if (ld) begin
            m_start = ext; m_cnt = 2'b00; m_fresh = 1'b1;
        end else if (!adv) begin
            m_cnt = m_cnt + 2'd1; m_fresh = 1'b0;
        end
        #1;
        check(tag, exp_beat(m_start, m_cnt, order_sel), m_fresh);
    endtask

    initial begin
        logic [1:0] want [4];
        void'($urandom(32'd1729));
        // R1: reset state
        repeat (3) @(posedge clk);
        #1;
        check("R1 reset", 2'b00, 1'b0);
        @(negedge clk);
        rst_n = 1'b1;

        // R3: interleaved, every start value, explicit sequences
        order_sel = 1'b1;
        for (int s = 0; s < 4; s++) begin
            cyc(1'b1, 1'b1, 2'(s), "R2 load interleaved");
            for (int b = 1; b < 4; b++)
                cyc(1'b0, 1'b0, 2'($urandom_range(0, 3)), "R3 interleaved step");
        end
        // R3: explicit table for start 01
        want = '{2'b01, 2'b00, 2'b11, 2'b10};
        cyc(1'b1, 1'b1, 2'b01, "R3 start 01");
        for (int b = 1; b < 4; b++) begin
            cyc(1'b0, 1'b0, 2'b00, "R3 start 01 beat");
            checks++;
            if (eff_lo !== want[b]) begin
                fails++;
                $display("FAIL R3 table: eff_lo=%b expected %b", eff_lo, want[b]);
            end
        end
        // R7: fourth advance wraps to start
        cyc(1'b0, 1'b0, 2'b10, "R7 wrap interleaved");
        checks++;
        if (eff_lo !== 2'b01) begin
            fails++;
            $display("FAIL R7: eff_lo=%b expected 01", eff_lo);
        end

        // R4: linear order after a reload
        order_sel = 1'b0;
        want = '{2'b01, 2'b10, 2'b11, 2'b00};
        cyc(1'b1, 1'b0, 2'b01, "R2 load overrides advance");
        for (int b = 1; b < 4; b++) begin
            cyc(1'b0, 1'b0, 2'b11, "R4 linear step");
            checks++;
            if (eff_lo !== want[b]) begin
                fails++;
                $display("FAIL R4 table: eff_lo=%b expected %b", eff_lo, want[b]);
            end
        end
        cyc(1'b0, 1'b0, 2'b00, "R7 wrap linear");
        for (int s = 0; s < 4; s++) begin
            cyc(1'b1, 1'b1, 2'(s), "R2 load linear");
            for (int b = 1; b < 5; b++)
                cyc(1'b0, 1'b0, 2'($urandom_range(0, 3)), "R4 linear R7 wrap");
        end

        // R6: suspend on the first beat and mid-burst
        cyc(1'b1, 1'b1, 2'b10, "R2 load before suspend");
        cyc(1'b0, 1'b1, 2'b01, "R6 suspend first beat");
        cyc(1'b0, 1'b0, 2'b01, "R5 advance after suspend");
        cyc(1'b0, 1'b1, 2'b11, "R6 suspend mid-burst");
        cyc(1'b0, 1'b1, 2'b00, "R8 ext ignored during suspend");

        // Random mix in each order; order only changes right before a load
        for (int ph = 0; ph < 2; ph++) begin
            order_sel = ph[0];
            cyc(1'b1, 1'($urandom_range(0, 1)), 2'($urandom_range(0, 3)), "R2 random load");
            for (int i = 0; i < 400; i++) begin
                logic ld;
                ld = ($urandom_range(0, 7) == 0);
                cyc(ld, 1'($urandom_range(0, 1)), 2'($urandom_range(0, 3)),
                    ld ? "R2 random load" : "R5 R6 R8 random step");
            end
        end

        // R1: reset mid-burst clears state
        @(negedge clk);
        rst_n = 1'b0;
        @(posedge clk);
        #1;
        check("R1 reset mid-burst", 2'b00, 1'b0);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    // Watchdog: a hung run counts as a failure
    initial begin
        #(20 * 50000);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule